// File: doc/BRIEF.md
# Self-Timed Flash Erase and Program Controller

This block sequences erase and program cycles on a word-addressed flash array. Software writes a 16-bit control register. Its low fifteen bits name an operation, and its top bit is a start flag that doubles as a busy flag. When software writes the register with the start flag set, the controller decodes the command and loads a busy timer with the duration parameter for that operation. When the timer expires, the controller performs the array action in one cycle and clears the start flag itself. Software detects completion by polling that flag.

There are four operations. A chip erase clears either the user words alone or the user and configuration words together. A page erase clears 512 words. A row program writes 64 words from a row buffer. A configuration write writes one word from a holding latch. Several values are held ahead of a cycle:
- a table page value, which selects the chip-erase scope;
- a target address;
- a row buffer, filled one word at a time through an index that steps after each load;
- a configuration data latch.

Erased words read as all ones, and programming can only clear bits. The array counts program operations per user word. A third program of a word before its page is erased raises a sticky violation flag, and the write still takes place.

Top module: `nvm_cycle_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, both flags are low, every user word and configuration word reads all ones, and the identification words read their fixed values.
- R2: Writing the control register with bit 15 set while bit 15 is low starts a cycle. Bit 15 then stays high for the duration parameter of the decoded operation: 40 cycles for chip erase, 24 for page erase, 16 for row program and 10 for configuration write. After that, bit 15 clears, and bits 14:0 keep the written value.
- R3: While bit 15 is high, the following writes are ignored: control-register writes, row-buffer loads, target-address writes and configuration-latch writes.
- R4: A start whose bits 14:0 match none of 0x404F, 0x4042, 0x4001 or 0x4003 keeps bit 15 high for exactly one cycle and touches no word. It also sets the command-error flag, which clears at the next start of a supported command.
- R5: Code 0x4001 (row program) replaces each of the 64 words of the row that contains the target address with the bitwise AND of the old word and its row-buffer slot. The row is aligned by clearing the address bits below 64.
- R6: Code 0x4042 (page erase) sets to all ones the 512 user words of the page that contains the target address. It also resets their write counts. Other words are unchanged.
- R7: Code 0x404F (chip erase) with a table page value below 0x80 sets every user word to all ones, resets all write counts, and leaves the configuration words unchanged.
- R8: Code 0x404F with a table page value of 0x80 or above also sets the configuration words to all ones. In every case the identification words keep their fixed values.
- R9: Each row program counts one write for each of its 64 user words. When a word that already holds two writes since its last erase is written again, the violation flag goes high and stays high until reset, and the AND is still applied.
- R10: Each row-buffer load writes the slot selected by the load index and then advances the index, which wraps from 63 to 0. When a row program completes, the index returns to 0 and every slot returns to all ones.
- R11: Code 0x4003 (configuration write) replaces the configuration word selected by the low two target-address bits with its AND with the configuration latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value; bit 15 starts a cycle |
| ctl_q | output | 16 | Control register contents; bit 15 is busy |
| tbl_we | input | 1 | Table page write strobe |
| tbl_page | input | 8 | Table page value, selects chip-erase scope |
| adr_we | input | 1 | Target address write strobe |
| adr_wdata | input | 10 | Target word address |
| buf_we | input | 1 | Row buffer load strobe |
| buf_wdata | input | 24 | Row buffer load word |
| cfg_we | input | 1 | Configuration latch write strobe |
| cfg_wdata | input | 24 | Configuration latch value |
| rd_addr | input | 11 | Read address: bit 10 low selects a user word; bit 10 high selects configuration words 0-3, then identification words 4-5, then all ones |
| rd_data | output | 24 | Word at rd_addr |
| cmd_err | output | 1 | Unsupported-command flag |
| wr_viol | output | 1 | Sticky over-write violation flag |

## Verification
Two events can land on the same clock edge: the completion of a cycle and a new register write, such as a control write, a buffer load or a latch update. The bench provokes this by driving all four write strobes on every busy cycle, including the last one, so that they are sampled on the completion edge. It then judges the result at the ports. The control register must hold the original command with bit 15 clear. The array must show the effect of the original target and data only. A following row program must see a freshly cleared buffer whose index is zero.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_CHIP = 3'd1,
      OP_PAGE = 3'd2,
      OP_ROW  = 3'd3,
      OP_CFG  = 3'd4
   } nvm_op_e;

   localparam logic [14:0] CODE_CHIP = 15'h404F;
   localparam logic [14:0] CODE_PAGE = 15'h4042;
   localparam logic [14:0] CODE_ROW  = 15'h4001;
   localparam logic [14:0] CODE_CFG  = 15'h4003;

   function automatic nvm_op_e nvm_decode(input logic [14:0] code);
      case (code)
         CODE_CHIP: return OP_CHIP;
         CODE_PAGE: return OP_PAGE;
         CODE_ROW:  return OP_ROW;
         CODE_CFG:  return OP_CFG;
         default:   return OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/nvm_seq.sv
module nvm_seq
   import nvm_pkg::*;
#(
   parameter int         T_CHIP     = 40,
   parameter int         T_PAGE     = 24,
   parameter int         T_ROW      = 16,
   parameter int         T_CFG      = 10,
   parameter logic [7:0] PAGE_SPLIT = 8'h80
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we,
   input  logic [15:0] ctl_wdata,
   input  logic [7:0]  page_now,
   output logic [15:0] ctl_q,
   output logic        busy,
   output logic        fire,
   output nvm_op_e     op_q,
   output logic        full_scope,
   output logic        cmd_err
);

   localparam int TMAX_A = (T_CHIP > T_PAGE) ? T_CHIP : T_PAGE;
   localparam int TMAX_B = (T_ROW > T_CFG) ? T_ROW : T_CFG;
   localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
   localparam int CW     = $clog2(TMAX + 1);

   logic [CW-1:0] cnt;
   nvm_op_e       dec;

   assign dec  = nvm_decode(ctl_wdata[14:0]);
   assign busy = ctl_q[15];
   assign fire = busy && (cnt == '0) && (op_q != OP_NONE);

   function automatic logic [CW-1:0] dur_of(input nvm_op_e op);
      case (op)
         OP_CHIP: return CW'(T_CHIP - 1);
         OP_PAGE: return CW'(T_PAGE - 1);
         OP_ROW:  return CW'(T_ROW - 1);
         OP_CFG:  return CW'(T_CFG - 1);
         default: return '0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         cnt        <= '0;
         op_q       <= OP_NONE;
         full_scope <= 1'b0;
         cmd_err    <= 1'b0;
      end else if (busy) begin
         if (cnt == '0) begin
            ctl_q[15] <= 1'b0;
            if (op_q == OP_NONE) cmd_err <= 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end else if (ctl_we) begin
         ctl_q <= ctl_wdata;
         if (ctl_wdata[15]) begin
            op_q       <= dec;
            cnt        <= dur_of(dec);
            full_scope <= (page_now >= PAGE_SPLIT);
            if (dec != OP_NONE) cmd_err <= 1'b0;
         end
      end
   end

   a_r3_ctl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_we) |=> (ctl_q[14:0] == $past(ctl_q[14:0])));

   a_r4_bad_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_we && ctl_wdata[15] && dec == OP_NONE) |=> busy ##1 (!busy && cmd_err));

   a_r2_fire_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !busy);

endmodule

// File: rtl/nvm_rowbuf.sv
module nvm_rowbuf #(
   parameter int ROW_WORDS = 64,
   parameter int DATA_W    = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_we,
   input  logic [DATA_W-1:0]           load_data,
   input  logic                        busy,
   input  logic                        clear,
   output logic [ROW_WORDS*DATA_W-1:0] row_flat
);

   localparam int RI_W = $clog2(ROW_WORDS);

   logic [RI_W-1:0] idx;
   logic            take;

   assign take = load_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (clear)  idx <= '0;
      else if (take)   idx <= idx + 1'b1;
   end

   for (genvar g = 0; g < ROW_WORDS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_flat[g*DATA_W +: DATA_W] <= '1;
         else if (clear)
            row_flat[g*DATA_W +: DATA_W] <= '1;
         else if (take && idx == RI_W'(g))
            row_flat[g*DATA_W +: DATA_W] <= load_data;
      end
   end

   a_r10_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load_we && !clear) |=> $stable(idx));

   a_r10_clear_resets_index: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (idx == '0));

endmodule

// File: rtl/nvm_array.sv
module nvm_array
   import nvm_pkg::*;
#(
   parameter int              DATA_W     = 24,
   parameter int              USER_WORDS = 1024,
   parameter int              PAGE_WORDS = 512,
   parameter int              ROW_WORDS  = 64,
   parameter int              CFG_WORDS  = 4,
   parameter int              ID_WORDS   = 2,
   parameter logic [23:0]     ID_BASE    = 24'h00A5C0,
   localparam int             UA_W       = $clog2(USER_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fire,
   input  nvm_op_e                     op,
   input  logic                        full_scope,
   input  logic [UA_W-1:0]             tgt_addr,
   input  logic [ROW_WORDS*DATA_W-1:0] row_flat,
   input  logic [DATA_W-1:0]           cfg_data,
   input  logic [UA_W:0]               rd_addr,
   output logic [DATA_W-1:0]           rd_data,
   output logic                        wr_viol
);

   localparam int              CI_W    = $clog2(CFG_WORDS);
   localparam logic [UA_W-1:0] PG_MASK = ~UA_W'(PAGE_WORDS - 1);
   localparam logic [UA_W-1:0] RW_MASK = ~UA_W'(ROW_WORDS - 1);

   logic [DATA_W-1:0] umem [USER_WORDS];
   logic [1:0]        wcnt [USER_WORDS];
   logic [DATA_W-1:0] cmem [CFG_WORDS];
   logic [UA_W-1:0]   pbase;
   logic [UA_W-1:0]   rbase;
   logic [UA_W-1:0]   rlow;

   assign pbase = tgt_addr & PG_MASK;
   assign rbase = tgt_addr & RW_MASK;
   assign rlow  = rd_addr[UA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < USER_WORDS; i++) begin
            umem[i] <= '1;
            wcnt[i] <= 2'd0;
         end
         for (int c = 0; c < CFG_WORDS; c++) cmem[c] <= '1;
         wr_viol <= 1'b0;
      end else if (fire) begin
         case (op)
            OP_CHIP: begin
               for (int i = 0; i < USER_WORDS; i++) begin
                  umem[i] <= '1;
                  wcnt[i] <= 2'd0;
               end
               if (full_scope)
                  for (int c = 0; c < CFG_WORDS; c++) cmem[c] <= '1;
            end
            OP_PAGE: begin
               for (int i = 0; i < PAGE_WORDS; i++) begin
                  umem[pbase + UA_W'(i)] <= '1;
                  wcnt[pbase + UA_W'(i)] <= 2'd0;
               end
            end
            OP_ROW: begin
               for (int i = 0; i < ROW_WORDS; i++) begin
                  umem[rbase + UA_W'(i)] <= umem[rbase + UA_W'(i)]
                                            & row_flat[i*DATA_W +: DATA_W];
                  if (wcnt[rbase + UA_W'(i)] == 2'd2)
                     wr_viol <= 1'b1;
                  else
                     wcnt[rbase + UA_W'(i)] <= wcnt[rbase + UA_W'(i)] + 2'd1;
               end
            end
            OP_CFG: begin
               cmem[tgt_addr[CI_W-1:0]] <= cmem[tgt_addr[CI_W-1:0]] & cfg_data;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (!rd_addr[UA_W])
         rd_data = umem[rlow];
      else if (rlow < UA_W'(CFG_WORDS))
         rd_data = cmem[rlow[CI_W-1:0]];
      else if (rlow < UA_W'(CFG_WORDS + ID_WORDS))
         rd_data = DATA_W'(ID_BASE) + DATA_W'(rlow - UA_W'(CFG_WORDS));
      else
         rd_data = '1;
   end

   a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      wr_viol |=> wr_viol);

   a_r9_viol_only_on_row: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_viol) |-> ($past(fire) && $past(op) == OP_ROW));

endmodule

// File: rtl/nvm_cycle_ctrl.sv
module nvm_cycle_ctrl
   import nvm_pkg::*;
#(
   parameter int          DATA_W     = 24,
   parameter int          USER_WORDS = 1024,
   parameter int          PAGE_WORDS = 512,
   parameter int          ROW_WORDS  = 64,
   parameter int          CFG_WORDS  = 4,
   parameter int          ID_WORDS   = 2,
   parameter logic [23:0] ID_BASE    = 24'h00A5C0,
   parameter int          T_CHIP     = 40,
   parameter int          T_PAGE     = 24,
   parameter int          T_ROW      = 16,
   parameter int          T_CFG      = 10,
   parameter logic [7:0]  PAGE_SPLIT = 8'h80,
   localparam int         UA_W       = $clog2(USER_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [15:0]       ctl_wdata,
   output logic [15:0]       ctl_q,
   input  logic              tbl_we,
   input  logic [7:0]        tbl_page,
   input  logic              adr_we,
   input  logic [UA_W-1:0]   adr_wdata,
   input  logic              buf_we,
   input  logic [DATA_W-1:0] buf_wdata,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [UA_W:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              cmd_err,
   output logic              wr_viol
);

   if (USER_WORDS != (1 << UA_W))        begin : g_chk_user  $error("USER_WORDS must be a power of two"); end
   if (PAGE_WORDS * 2 > USER_WORDS)      begin : g_chk_page  $error("need at least two pages"); end
   if (PAGE_WORDS % ROW_WORDS != 0)      begin : g_chk_row   $error("page must hold whole rows"); end
   if (ROW_WORDS != (1 << $clog2(ROW_WORDS))) begin : g_chk_rowp $error("ROW_WORDS must be a power of two"); end
   if (CFG_WORDS < 2 || CFG_WORDS + ID_WORDS > USER_WORDS) begin : g_chk_cfg $error("bad CFG_WORDS"); end
   if (T_CHIP < 1 || T_PAGE < 1 || T_ROW < 1 || T_CFG < 1) begin : g_chk_t $error("durations must be >= 1"); end

   logic [7:0]        page_q;
   logic [UA_W-1:0]   adr_q;
   logic [DATA_W-1:0] cfg_q;
   logic              busy;
   logic              fire;
   logic              full_scope;
   nvm_op_e           op_q;
   logic [ROW_WORDS*DATA_W-1:0] row_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         adr_q  <= '0;
         cfg_q  <= '1;
      end else begin
         if (tbl_we)           page_q <= tbl_page;
         if (adr_we && !busy)  adr_q  <= adr_wdata;
         if (cfg_we && !busy)  cfg_q  <= cfg_wdata;
      end
   end

   nvm_seq #(
      .T_CHIP(T_CHIP), .T_PAGE(T_PAGE), .T_ROW(T_ROW), .T_CFG(T_CFG),
      .PAGE_SPLIT(PAGE_SPLIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .page_now(page_q), .ctl_q(ctl_q), .busy(busy), .fire(fire),
      .op_q(op_q), .full_scope(full_scope), .cmd_err(cmd_err)
   );

   nvm_rowbuf #(.ROW_WORDS(ROW_WORDS), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .load_we(buf_we), .load_data(buf_wdata),
      .busy(busy), .clear(fire && op_q == OP_ROW), .row_flat(row_flat)
   );

   nvm_array #(
      .DATA_W(DATA_W), .USER_WORDS(USER_WORDS), .PAGE_WORDS(PAGE_WORDS),
      .ROW_WORDS(ROW_WORDS), .CFG_WORDS(CFG_WORDS), .ID_WORDS(ID_WORDS),
      .ID_BASE(ID_BASE)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .fire(fire), .op(op_q), .full_scope(full_scope),
      .tgt_addr(adr_q), .row_flat(row_flat), .cfg_data(cfg_q),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_viol(wr_viol)
   );

   a_r3_adr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && adr_we) |=> $stable(adr_q));

   a_r4_bad_cmd_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_err) |-> !$past(fire));

endmodule

// File: tb/nvm_cycle_ctrl_test.sv
module nvm_cycle_ctrl_test;

   localparam int UW = 1024;
   localparam int PW = 512;
   localparam int RW = 64;
   localparam int CW = 4;
   localparam int IW = 2;
   localparam logic [23:0] IDB = 24'h00A5C0;
   localparam int D_CHIP = 40, D_PAGE = 24, D_ROW = 16, D_CFG = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 0;
   logic [15:0] ctl_wdata = 0;
   logic [15:0] ctl_q;
   logic        tbl_we = 0;
   logic [7:0]  tbl_page = 0;
   logic        adr_we = 0;
   logic [9:0]  adr_wdata = 0;
   logic        buf_we = 0;
   logic [23:0] buf_wdata = 0;
   logic        cfg_we = 0;
   logic [23:0] cfg_wdata = 0;
   logic [10:0] rd_addr = 0;
   logic [23:0] rd_data;
   logic        cmd_err;
   logic        wr_viol;

   always #2.5 clk = ~clk;

   nvm_cycle_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
      .tbl_we(tbl_we), .tbl_page(tbl_page), .adr_we(adr_we), .adr_wdata(adr_wdata),
      .buf_we(buf_we), .buf_wdata(buf_wdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data), .cmd_err(cmd_err), .wr_viol(wr_viol)
   );

   int checks = 0;
   int errors = 0;

   logic [23:0] m_user [UW];
   int          m_cnt  [UW];
   logic [23:0] m_cfg  [CW];
   logic [23:0] m_buf  [RW];
   int          m_idx;
   bit          m_viol;
   logic [9:0]  cur_adr;
   logic [7:0]  cur_tbl;
   logic [23:0] cur_cfg;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   function automatic logic [23:0] exp_rd(input int a);
      if (a < UW) return m_user[a];
      if (a < UW + CW) return m_cfg[a - UW];
      if (a < UW + CW + IW) return IDB + 24'(a - UW - CW);
      return 24'hFFFFFF;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < UW; i++) begin m_user[i] = '1; m_cnt[i] = 0; end
      for (int c = 0; c < CW; c++) m_cfg[c] = '1;
      for (int s = 0; s < RW; s++) m_buf[s] = '1;
      m_idx = 0; m_viol = 0; cur_adr = 0; cur_tbl = 0; cur_cfg = '1;
   endtask

   task automatic m_row();
      int base;
      base = int'(cur_adr) & ~(RW - 1);
      for (int i = 0; i < RW; i++) begin
         m_user[base + i] = m_user[base + i] & m_buf[i];
         if (m_cnt[base + i] == 2) m_viol = 1;
         else m_cnt[base + i]++;
      end
      for (int s = 0; s < RW; s++) m_buf[s] = '1;
      m_idx = 0;
   endtask

   task automatic m_page();
      int base;
      base = int'(cur_adr) & ~(PW - 1);
      for (int i = 0; i < PW; i++) begin m_user[base + i] = '1; m_cnt[base + i] = 0; end
   endtask

   task automatic m_chip();
      for (int i = 0; i < UW; i++) begin m_user[i] = '1; m_cnt[i] = 0; end
      if (cur_tbl >= 8'h80) for (int c = 0; c < CW; c++) m_cfg[c] = '1;
   endtask

   task automatic buf_push(input logic [23:0] d);
      buf_we = 1; buf_wdata = d;
      @(negedge clk);
      buf_we = 0;
      m_buf[m_idx] = d;
      m_idx = (m_idx + 1) % RW;
   endtask

   task automatic set_adr(input logic [9:0] a);
      adr_we = 1; adr_wdata = a;
      @(negedge clk);
      adr_we = 0; cur_adr = a;
   endtask

   task automatic set_tbl(input logic [7:0] p);
      tbl_we = 1; tbl_page = p;
      @(negedge clk);
      tbl_we = 0; cur_tbl = p;
   endtask

   task automatic set_cfg(input logic [23:0] d);
      cfg_we = 1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0; cur_cfg = d;
   endtask

   task automatic run_op(input logic [14:0] code, input int exp_dur, input bit poke, input string tag);
      int n;
      ctl_we = 1; ctl_wdata = {1'b1, code};
      @(negedge clk);
      ctl_we = 0;
      n = 0;
      while (ctl_q[15] && n < 1000) begin
         n++;
         if (poke) begin
            ctl_we = 1; ctl_wdata = 16'hC04F;
            buf_we = 1; buf_wdata = 24'h000000;
            adr_we = 1; adr_wdata = ~cur_adr;
            cfg_we = 1; cfg_wdata = 24'h000000;
         end
         @(negedge clk);
      end
      ctl_we = 0; buf_we = 0; adr_we = 0; cfg_we = 0;
      chk(n == exp_dur, {tag, " busy cycles"}, n, exp_dur);
      chk(ctl_q == {1'b0, code}, {tag, " control after cycle"}, ctl_q, {1'b0, code});
      case (code)
         15'h404F: m_chip();
         15'h4042: m_page();
         15'h4001: m_row();
         15'h4003: m_cfg[cur_adr[1:0]] = m_cfg[cur_adr[1:0]] & cur_cfg;
         default: ;
      endcase
   endtask

   task automatic check_mem(input string tag);
      int bad;
      int first;
      logic [23:0] fa, fe;
      bad = 0; first = -1; fa = 0; fe = 0;
      for (int a = 0; a < UW + CW + IW + 1; a++) begin
         rd_addr = 11'(a);
         #0.5;
         if (rd_data !== exp_rd(a)) begin
            if (first < 0) begin first = a; fa = rd_data; fe = exp_rd(a); end
            bad++;
         end
      end
      @(negedge clk);
      if (bad != 0) $display("  first mismatch at word %0h", first);
      chk(bad == 0, {tag, " memory contents"}, fa, fe);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk(ctl_q == 16'h0000, "R1 control reset", ctl_q, 0);
      chk(cmd_err == 0, "R1 error flag reset", cmd_err, 0);
      chk(wr_viol == 0, "R1 violation flag reset", wr_viol, 0);
      check_mem("R1");

      // R5 row program at unaligned address, R2 row duration
      set_adr(10'd197);
      for (int k = 0; k < RW; k++) buf_push(24'hF0F0F0 ^ 24'(k * 24'h010203));
      run_op(15'h4001, D_ROW, 0, "R2 R5 row");
      check_mem("R5 row AND");

      // R10 index wrap: 70 loads fill slots 0..63 then overwrite 0..5
      set_adr(10'd320);
      for (int k = 0; k < 70; k++) buf_push(24'(32'h00FFFF00 >> (k % 9)));
      // R3 all writes during busy ignored
      run_op(15'h4001, D_ROW, 1, "R3 R10 row with pokes");
      check_mem("R3 R10 wrap and pokes");
      chk(wr_viol == m_viol, "R3 violation flag", wr_viol, m_viol);

      // R10 index back at slot 0 and buffer refilled with ones
      set_adr(10'd384);
      buf_push(24'h123456);
      run_op(15'h4001, D_ROW, 0, "R10 single load row");
      check_mem("R10 index reset");

      // R9 / R6: two writes, erase resets count, no violation
      set_adr(10'd640);
      buf_push(24'hFFFF0F);
      run_op(15'h4001, D_ROW, 0, "R9 first write");
      buf_push(24'hFF0FFF);
      run_op(15'h4001, D_ROW, 0, "R9 second write");
      chk(wr_viol == 0, "R9 two writes no violation", wr_viol, 0);
      run_op(15'h4042, D_PAGE, 0, "R2 R6 page erase");
      check_mem("R6 page erase");
      buf_push(24'h0FFFFF);
      run_op(15'h4001, D_ROW, 0, "R9 after erase");
      chk(wr_viol == 0, "R6 R9 count reset by erase", wr_viol, 0);
      buf_push(24'hFFFFF0);
      run_op(15'h4001, D_ROW, 0, "R9 second after erase");
      chk(wr_viol == 0, "R9 still two writes", wr_viol, 0);
      buf_push(24'hF0FFFF);
      run_op(15'h4001, D_ROW, 0, "R9 third write");
      chk(wr_viol == 1, "R9 third write flags", wr_viol, 1);
      check_mem("R9 third write still applied");

      // R11 configuration word write, with pokes during busy (R3)
      set_adr(10'd2);
      set_cfg(24'hA5A5A5);
      run_op(15'h4003, D_CFG, 1, "R2 R11 cfg write");
      set_adr(10'd5);
      set_cfg(24'h3C3CFF);
      run_op(15'h4003, D_CFG, 0, "R11 cfg write index 1");
      check_mem("R11 cfg words");

      // R4 unsupported command
      run_op(15'h4005, 1, 0, "R4 bad command");
      chk(cmd_err == 1, "R4 error flag set", cmd_err, 1);
      check_mem("R4 no array change");
      run_op(15'h4042, D_PAGE, 0, "R4 valid after bad");
      chk(cmd_err == 0, "R4 error flag cleared by valid start", cmd_err, 0);

      // R7 user-only chip erase
      set_adr(10'd100);
      buf_push(24'h000000);
      run_op(15'h4001, D_ROW, 0, "R7 prep row");
      set_tbl(8'h7F);
      run_op(15'h404F, D_CHIP, 0, "R2 R7 chip erase user");
      check_mem("R7 config kept");

      // R8 full chip erase, identification words kept
      set_tbl(8'h80);
      run_op(15'h404F, D_CHIP, 0, "R8 chip erase full");
      check_mem("R8 config cleared ids kept");

      // Random mix
      for (int it = 0; it < 30; it++) begin
         int sel;
         sel = int'($urandom % 8);
         if (sel < 4) begin
            set_adr(10'($urandom));
            for (int k = 0; k < int'($urandom % 70); k++) buf_push(24'($urandom | $urandom));
            run_op(15'h4001, D_ROW, sel == 0, "R5 random row");
         end else if (sel < 6) begin
            set_adr(10'($urandom));
            run_op(15'h4042, D_PAGE, 0, "R6 random page erase");
         end else if (sel == 6) begin
            set_adr(10'($urandom));
            set_cfg(24'($urandom | $urandom));
            run_op(15'h4003, D_CFG, 0, "R11 random cfg");
         end else begin
            set_tbl(8'h70 + 8'($urandom % 32));
            run_op(15'h404F, D_CHIP, 0, "R7 R8 random chip erase");
         end
         chk(wr_viol == m_viol, "R9 random violation flag", wr_viol, m_viol);
      end
      check_mem("R5 R6 R11 random final");

      finish_run();
   end

endmodule